// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

The block collects 64 raw interrupt lines into two banks of 32 and drives one combined interrupt request to a single processor. Each line has a fixed trigger mode. In edge mode, a rising edge of the sampled line sets a sticky pending bit that software must acknowledge. In level mode, the line raises a request for as long as it is held high, and it never creates a pending bit. Each bank also keeps an enable mask and a live copy of its input levels.

Software uses a synchronous 32-bit register port.
- A write is a single-cycle strobe.
- Read data appears on the cycle after the read strobe and holds until the next read.
- Bank A occupies byte offsets 0x10 to 0x1F and bank B occupies 0x20 to 0x2F.
- The inputs are crossed: lines 0 to 31 land in bank B and lines 32 to 63 land in bank A.

Only bank B bits 20 to 28 are level-mode. These are lines 20 to 28. All other lines are edge-mode.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, `irqOut` is 0 and every readable register (pending, enable, level) reads 0.
- R2: Bits [11:4] of `addr` select the bank. The value 1 selects bank A and 2 selects bank B. Any other value reads 0 and ignores writes.
- R3: Bits [3:0] of `addr` select the register within a bank.
  - 0x4 is the enable mask and can be read and written.
  - 0x0 reads the pending events.
  - 0xC reads the live levels.
  - 0x8 is the write-only acknowledge register and reads 0.
  - Any other nibble reads 0 and ignores writes. The read-only registers ignore writes.
- R4: Line k with k < 32 maps to bank B bit k. Line k with k >= 32 maps to bank A bit k-32.
- R5: In an edge-mode line, a low-to-high change of the sampled input sets its pending bit. A line held high after acknowledge does not set the bit again.
- R6: A falling input clears only its level bit. A set pending bit stays set until it is acknowledged.
- R7: Writing to the acknowledge offset clears each edge-mode pending bit written as 1. Level-mode bits are not affected.
- R8: `irqOut` is the OR over both banks of (pending OR (level AND level-mode)) AND enable. It is registered, so it reflects the register state one cycle after an input, mask or acknowledge update.
- R9: A level-mode line raises a request while high, even after an acknowledge. It drops the request when low, and it never shows in the pending register. The lines on either side of the level-mode range (19 and 29) behave as edge-mode.
- R10: `rdData` is registered and changes only on the cycle after a cycle with `rdEn` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 12 | Byte address within the block |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| irqIn | input | 64 | Raw interrupt lines |
| irqOut | output | 1 | Combined processor interrupt request |

## Verification
The assertions assume the following about the inputs:
- `irqIn` is already synchronous to `clk`, so each sampled change is a real edge.
- `wrEn` and `rdEn` are never both high with an undefined address.

The stimulus follows both rules. It changes lines and strobes only at the falling clock edge and always pairs a strobe with a defined address. After each change, it waits two rising edges before it looks at `irqOut`, so that the level register and the output register have both updated.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W     = 32;
  localparam int NUM_BANKS  = 2;
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  // Register offsets inside one bank window
  localparam logic [3:0] OFF_EVT  = 4'h0;
  localparam logic [3:0] OFF_MASK = 4'h4;
  localparam logic [3:0] OFF_ACK  = 4'h8;
  localparam logic [3:0] OFF_LVL  = 4'hC;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_LVL  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0]  maskWr;
    logic [NUM_BANKS-1:0]  ackWr;
    logic                  rdStb;
    rdSel_e                rdSel;
    logic [BANK_IDX_W-1:0] rdBank;
  } ctlStb_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStb_t           stb
);
  localparam int WIN_W = ADDR_W - 4;

  logic [WIN_W-1:0]      winIdx;
  logic [WIN_W-1:0]      winRel;
  logic [3:0]            regOff;
  logic                  bankHit;
  logic [BANK_IDX_W-1:0] bankIdx;

  assign winIdx  = addr[ADDR_W-1:4];
  assign regOff  = addr[3:0];
  assign winRel  = winIdx - WIN_W'(1);
  assign bankHit = (winIdx >= WIN_W'(1)) && (winIdx <= WIN_W'(NUM_BANKS));
  assign bankIdx = winRel[BANK_IDX_W-1:0];

  always_comb begin
    stb        = '0;
    stb.rdSel  = SEL_NONE;
    stb.rdStb  = rdEn;
    stb.rdBank = bankIdx;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wrEn && bankHit && (bankIdx == BANK_IDX_W'(b))) begin
        stb.maskWr[b] = (regOff == OFF_MASK);
        stb.ackWr[b]  = (regOff == OFF_ACK);
      end
    end
    if (bankHit) begin
      case (regOff)
        OFF_EVT:  stb.rdSel = SEL_EVT;
        OFF_MASK: stb.rdSel = SEL_MASK;
        OFF_LVL:  stb.rdSel = SEL_LVL;
        default:  stb.rdSel = SEL_NONE;
      endcase
    end
  end

  // R2
  wr_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.maskWr, stb.ackWr}));

  // R2
  outside_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((addr[ADDR_W-1:4] == '0) || (addr[ADDR_W-1:4] > WIN_W'(NUM_BANKS)))
      |-> ((stb.maskWr == '0) && (stb.ackWr == '0) && (stb.rdSel == SEL_NONE)));

  // R3
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ((stb.maskWr == '0) && (stb.ackWr == '0)));
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter logic [BANK_W-1:0] LVL_MODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BANK_W-1:0] lineIn,
  input  logic              maskWr,
  input  logic              ackWr,
  input  logic [BANK_W-1:0] wrData,
  output logic [BANK_W-1:0] events,
  output logic [BANK_W-1:0] mask,
  output logic [BANK_W-1:0] levels,
  output logic              request
);
  logic [BANK_W-1:0] riseHit;
  logic [BANK_W-1:0] ackBits;

  // A rise is measured against the previously sampled level
  assign riseHit = lineIn & ~levels & ~LVL_MODE;
  assign ackBits = ackWr ? (wrData & ~LVL_MODE) : '0;
  assign request = |((events | (levels & LVL_MODE)) & mask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      events <= '0;
      mask   <= '0;
      levels <= '0;
    end else begin
      levels <= lineIn;
      events <= (events & ~ackBits) | riseHit;
      if (maskWr) mask <= wrData;
    end
  end

  // R9
  lvl_never_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (events & LVL_MODE) == '0);

  // R6
  sticky_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ackWr |=> ((events & $past(events)) == $past(events)));

  // R5
  set_needs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((events & ~$past(events) & ~($past(lineIn) & ~$past(levels))) == '0));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskWr |=> $stable(mask));
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter logic [NUM_BANKS*BANK_W-1:0] LVL_MODE = '0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStb_t                     stb,
  input  logic [BANK_W-1:0]           wrData,
  input  logic [NUM_BANKS*BANK_W-1:0] irqIn,
  output logic [BANK_W-1:0]           rdData,
  output logic                        irqOut
);
  logic [BANK_W-1:0]    evtArr  [NUM_BANKS];
  logic [BANK_W-1:0]    maskArr [NUM_BANKS];
  logic [BANK_W-1:0]    lvlArr  [NUM_BANKS];
  logic [NUM_BANKS-1:0] reqVec;
  logic [BANK_W-1:0]    rdNext;
  logic                 anyMask;

  // Lines are crossed: bank b takes the slice counted from the top
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intc_bank #(
      .LVL_MODE(LVL_MODE[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (irqIn[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
      .maskWr (stb.maskWr[b]),
      .ackWr  (stb.ackWr[b]),
      .wrData (wrData),
      .events (evtArr[b]),
      .mask   (maskArr[b]),
      .levels (lvlArr[b]),
      .request(reqVec[b])
    );
  end

  always_comb begin
    anyMask = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) anyMask = anyMask | (|maskArr[b]);
  end

  always_comb begin
    case (stb.rdSel)
      SEL_EVT:  rdNext = evtArr[stb.rdBank];
      SEL_MASK: rdNext = maskArr[stb.rdBank];
      SEL_LVL:  rdNext = lvlArr[stb.rdBank];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      irqOut <= 1'b0;
    end else begin
      irqOut <= |reqVec;
      if (stb.rdStb) rdData <= rdNext;
    end
  end

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyMask |=> !irqOut);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStb |=> $stable(rdData));
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [NUM_BANKS*BANK_W-1:0] LVL_MODE = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wrData,
  output logic [BANK_W-1:0]           rdData,
  input  logic [NUM_BANKS*BANK_W-1:0] irqIn,
  output logic                        irqOut
);
  ctlStb_t stb;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .stb (stb)
  );

  intc_datapath #(.LVL_MODE(LVL_MODE)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(wrData),
    .irqIn (irqIn),
    .rdData(rdData),
    .irqOut(irqOut)
  );
endmodule

// File: tb/dual_bank_intc_bench.sv
module dual_bank_intc_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] irqIn = '0;
  logic        irqOut;

  int testsRun = 0;
  int testsFail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } rdItem_t;
  rdItem_t sbQ[$];
  logic rdSeen = 1'b0;

  always #5 clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqIn(irqIn), .irqOut(irqOut)
  );

  always @(posedge clk) rdSeen <= rdEn;

  // Monitor: pops one expected read result per completed read
  always @(negedge clk) begin
    if (rdSeen) begin
      rdItem_t it;
      testsRun++;
      if (sbQ.size() == 0) begin
        testsFail++;
        $display("FAIL %s: read without expectation, got %08h", "R10", rdData);
      end else begin
        it = sbQ.pop_front();
        if (rdData !== it.val) begin
          testsFail++;
          $display("FAIL %s: rdData=%08h expected %08h", it.tag, rdData, it.val);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    rdItem_t it;
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    it.val = exp; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Call after a write returns, or two negedges after a line change
  task automatic chkIrq(input logic exp, input string tag);
    @(negedge clk);
    testsRun++;
    if (irqOut !== exp) begin
      testsFail++;
      $display("FAIL %s: irqOut=%0b expected %0b", tag, irqOut, exp);
    end
  endtask

  task automatic setLine(input int k, input logic v);
    @(negedge clk);
    irqIn[k] = v;
    @(negedge clk);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testsRun++;
    if (irqOut !== 1'b0 || rdData !== 32'h0) begin
      testsFail++;
      $display("FAIL R1: irqOut=%0b rdData=%08h expected 0 0", irqOut, rdData);
    end
    rd(12'h010, 32'h0, "R1 bankA pending");
    rd(12'h024, 32'h0, "R1 bankB mask");
    rd(12'h02C, 32'h0, "R1 bankB level");

    // Register map
    wr(12'h014, 32'hA5A5_0F0F);
    rd(12'h014, 32'hA5A5_0F0F, "R3 mask A readback");
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h024, 32'hFFFF_FFFF, "R3 mask B readback");
    rd(12'h018, 32'h0, "R3 ack reads zero");
    wr(12'h01C, 32'h0000_1234);
    rd(12'h01C, 32'h0, "R3 level ignores write");
    wr(12'h034, 32'hFFFF_FFFF);
    rd(12'h034, 32'h0, "R2 window 3 reads zero");
    rd(12'h004, 32'h0, "R2 window 0 reads zero");
    rd(12'h014, 32'hA5A5_0F0F, "R2 mask A untouched");
    wr(12'h015, 32'h0);
    rd(12'h014, 32'hA5A5_0F0F, "R3 odd nibble ignored");
    rd(12'h011, 32'h0, "R3 odd nibble reads zero");
    wr(12'h014, 32'h0);
    wr(12'h024, 32'h0);

    // Edge line 3 -> bank B bit 3
    setLine(3, 1'b1);
    rd(12'h020, 32'h0000_0008, "R4 line3 pending in B");
    rd(12'h02C, 32'h0000_0008, "R4 line3 level in B");
    rd(12'h010, 32'h0, "R4 bank A untouched");
    chkIrq(1'b0, "R8 masked");
    wr(12'h024, 32'h0000_0008);
    chkIrq(1'b1, "R8 enabled");
    setLine(3, 1'b0);
    rd(12'h02C, 32'h0, "R6 level cleared");
    rd(12'h020, 32'h0000_0008, "R6 pending sticky");
    chkIrq(1'b1, "R6 request held");
    wr(12'h028, 32'h0000_0008);
    chkIrq(1'b0, "R7 ack drops request");
    rd(12'h020, 32'h0, "R7 pending cleared");
    setLine(3, 1'b1);
    rd(12'h020, 32'h0000_0008, "R5 second rise");
    wr(12'h028, 32'h0000_0008);
    idle(3);
    rd(12'h020, 32'h0, "R5 held high no relatch");
    setLine(3, 1'b0);
    wr(12'h024, 32'h0);

    // Line 37 -> bank A bit 5
    setLine(37, 1'b1);
    rd(12'h010, 32'h0000_0020, "R4 line37 in A");
    rd(12'h020, 32'h0, "R4 bank B untouched");
    wr(12'h014, 32'h0000_0020);
    chkIrq(1'b1, "R8 bank A request");
    wr(12'h018, 32'h0000_0020);
    chkIrq(1'b0, "R7 ack with line high");
    setLine(37, 1'b0);
    wr(12'h014, 32'h0);

    // Level line 22 -> bank B bit 22
    wr(12'h024, 32'h0040_0000);
    setLine(22, 1'b1);
    chkIrq(1'b1, "R9 level request");
    rd(12'h020, 32'h0, "R9 level not pending");
    rd(12'h02C, 32'h0040_0000, "R9 level visible");
    wr(12'h028, 32'hFFFF_FFFF);
    chkIrq(1'b1, "R7 ack ignores level bit");
    setLine(22, 1'b0);
    chkIrq(1'b0, "R9 level released");
    wr(12'h024, 32'h0);

    // Boundaries of the level range
    setLine(19, 1'b1);
    setLine(19, 1'b0);
    setLine(28, 1'b1);
    setLine(29, 1'b1);
    rd(12'h020, 32'h2008_0000, "R9 bits 19 and 29 edge");
    rd(12'h02C, 32'h3000_0000, "R9 levels 28 29");
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h020, 32'h0, "R7 ack all edge bits");
    setLine(28, 1'b0);
    setLine(29, 1'b0);

    // Top line into bank A bit 31, combined output
    setLine(63, 1'b1);
    setLine(63, 1'b0);
    chkIrq(1'b0, "R8 all masked");
    wr(12'h014, 32'h8000_0000);
    chkIrq(1'b1, "R8 bank A bit31");
    wr(12'h014, 32'h0);
    chkIrq(1'b0, "R8 mask removed");
    wr(12'h038, 32'hFFFF_FFFF);
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h010, 32'h8000_0000, "R2 stray ack ignored");

    // rdData holds while idle
    idle(3);
    testsRun++;
    if (rdData !== 32'h8000_0000) begin
      testsFail++;
      $display("FAIL R10: rdData=%08h expected %08h", rdData, 32'h8000_0000);
    end

    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end
endmodule